// File: doc/BRIEF.md
# Coherent-Port Burst Splitter

This block turns one DMA transfer command into a stream of small, aligned INCR address bursts that a cache-coherent port will accept. The command gives a start address, a byte count and a direction. The block walks the range and decides each burst from the current address and the bytes still to move. A burst is either a full 64-byte line or a single 16-byte chunk, so software never has to split a long job into port-sized pieces.

The data bus is 16 bytes wide. A line burst is four beats and a chunk burst is one beat. Up to four bursts may be waiting for their responses at once. The block counts the responses that come back and pulses `done` when all of them have returned. An error response on any burst is latched and reported with `done`. A command that cannot be split into aligned 16-byte pieces is refused when it is accepted: it is flagged as an error at once and sends no bursts.

Top module: `coh_burst_splitter`

## Requirements
- R1: Every burst is INCR (`ax_burst` = 2'b01) with `ax_size` = 4 (16-byte beats). `ax_len` is either 3 (a 64-byte line) or 0 (a 16-byte chunk).
- R2: A line burst starts at a 64-byte aligned address. A chunk burst starts at a 16-byte aligned address.
- R3: A line burst is issued when the current address is 64-byte aligned and at least 64 bytes remain. In every other case a chunk burst is issued.
- R4: The bursts of one command are contiguous. They start at the command address, each begins where the previous one ended, and their sizes add up to exactly the command length.
- R5: A command whose address or length has a nonzero value in bits [3:0] is refused. `done` and `err` pulse together and no burst is issued.
- R6: A zero-length command pulses `done` with `err` low and issues no burst.
- R7: No more than 4 bursts are ever outstanding, counted from address handshakes to responses. A long transfer with slow responses reaches that limit.
- R8: `done` is a single-cycle pulse. It is raised only after every issued burst has received its response.
- R9: If any response has `resp_code[1]` set (2'b10 slave error, 2'b11 decode error), `err` pulses together with `done`. If every response is 2'b00, `err` stays low.
- R10: Once `ax_valid` is high, it stays high until `ax_ready` is sampled high. `ax_addr`, `ax_len` and `ax_write` stay stable over that time.
- R11: `cmd_ready` is low while a transfer is in progress. A command presented during that time is ignored and does not change the burst stream.
- R12: `ax_write` on every burst equals the `cmd_write` value of the command that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_addr | input | 32 | Transfer start byte address |
| cmd_bytes | input | 16 | Transfer length in bytes |
| cmd_write | input | 1 | 1 = write transfer, 0 = read transfer |
| ax_valid | output | 1 | Burst address valid |
| ax_ready | input | 1 | Port takes the burst address |
| ax_addr | output | 32 | Burst start address |
| ax_len | output | 8 | Beats minus one (0 or 3) |
| ax_size | output | 3 | Beat size code, always 4 |
| ax_burst | output | 2 | Burst type, always INCR |
| ax_write | output | 1 | Direction of the burst |
| resp_valid | input | 1 | One burst response returns |
| resp_code | input | 2 | Response code, bit 1 set means error |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error flag, valid with done |

## Verification
The bench looks hardest at the points where a split decision changes. It uses a start 16 bytes past a line boundary, a tail shorter than a line after full lines, and a range that is aligned to a line but is not a multiple of one. A splitter that tested only the length would emit a misaligned line burst, and one that tested only the address would run past the end of the range. The bench checks commands with a bad address or a bad length, and a zero-length command. A design that forgot either check would put bursts on the bus or never finish. It also stalls `ax_ready` to catch an address that moves before its handshake. It slows the responses to show that the credit limit of four holds and that `done` waits for the last response. Finally, it returns one error mid-stream, which a design that latched only the final response would miss.

// File: rtl/cpb_pkg.sv
package cpb_pkg;
    parameter int ADDR_W     = 32;
    parameter int LEN_W      = 16;
    parameter int BEAT_BYTES = 16;
    parameter int LINE_BYTES = 64;

    localparam int BEAT_LSB = $clog2(BEAT_BYTES);
    localparam int LINE_LSB = $clog2(LINE_BYTES);

    localparam logic [7:0] LINE_AXLEN  = 8'(LINE_BYTES / BEAT_BYTES - 1);
    localparam logic [7:0] CHUNK_AXLEN = 8'd0;
    localparam logic [2:0] AXSIZE      = 3'(BEAT_LSB);
    localparam logic [1:0] BURST_INCR  = 2'b01;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [LEN_W-1:0]  len_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_DRAIN
    } state_e;

    typedef struct packed {
        addr_t      addr;
        logic [7:0] axlen;
        len_t       bytes;
        logic       last;
    } burst_t;

    // a full line fits when the cursor sits on a line boundary and enough bytes remain
    function automatic logic fits_line(addr_t a, len_t r);
        return (a[LINE_LSB-1:0] == '0) && (r >= len_t'(LINE_BYTES));
    endfunction
endpackage

// File: rtl/cpb_cmd_check.sv
module cpb_cmd_check
    import cpb_pkg::*;
(
    input  logic [BEAT_LSB-1:0] addr_lo,
    input  len_t                bytes,
    output logic                bad,
    output logic                empty
);
    always_comb begin
        bad   = (addr_lo != '0) || (bytes[BEAT_LSB-1:0] != '0);
        empty = (bytes == '0);
    end
endmodule

// File: rtl/cpb_walker.sv
module cpb_walker
    import cpb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  addr_t  load_addr,
    input  len_t   load_bytes,
    input  logic   step,
    output burst_t nxt
);
    addr_t cur;
    len_t  rem;
    logic  use_line;

    always_comb begin
        use_line  = fits_line(cur, rem);
        nxt.addr  = cur;
        nxt.axlen = use_line ? LINE_AXLEN : CHUNK_AXLEN;
        nxt.bytes = use_line ? len_t'(LINE_BYTES) : len_t'(BEAT_BYTES);
        nxt.last  = (rem == nxt.bytes);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
            rem <= '0;
        end else if (load) begin
            cur <= load_addr;
            rem <= load_bytes;
        end else if (step) begin
            cur <= cur + addr_t'(nxt.bytes);
            rem <= rem - nxt.bytes;
        end
    end
endmodule

// File: rtl/cpb_credit.sv
module cpb_credit #(
    parameter int MAX_OUT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic give,
    output logic room,
    output logic drained
);
    localparam int CW = $clog2(MAX_OUT + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            unique case ({take, give})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    always_comb begin
        room    = (cnt < CW'(MAX_OUT));
        drained = (cnt == '0);
    end
endmodule

// File: rtl/coh_burst_splitter.sv
module coh_burst_splitter
    import cpb_pkg::*;
#(
    parameter int MAX_OUTSTANDING = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_bytes,
    input  logic              cmd_write,
    output logic              ax_valid,
    input  logic              ax_ready,
    output logic [ADDR_W-1:0] ax_addr,
    output logic [7:0]        ax_len,
    output logic [2:0]        ax_size,
    output logic [1:0]        ax_burst,
    output logic              ax_write,
    input  logic              resp_valid,
    input  logic [1:0]        resp_code,
    output logic              done,
    output logic              err
);
    state_e state;
    burst_t nb;
    logic   bad, empty, room, drained;
    logic   cmd_fire, ax_fire, resp_err;
    logic   done_q, err_q, err_seen, wr_q;

    cpb_cmd_check u_check (
        .addr_lo (cmd_addr[BEAT_LSB-1:0]),
        .bytes   (cmd_bytes),
        .bad     (bad),
        .empty   (empty)
    );

    cpb_walker u_walk (
        .clk        (clk),
        .rst        (rst),
        .load       (cmd_fire && !bad && !empty),
        .load_addr  (cmd_addr),
        .load_bytes (cmd_bytes),
        .step       (ax_fire),
        .nxt        (nb)
    );

    cpb_credit #(.MAX_OUT(MAX_OUTSTANDING)) u_credit (
        .clk     (clk),
        .rst     (rst),
        .take    (ax_fire),
        .give    (resp_valid),
        .room    (room),
        .drained (drained)
    );

    always_comb begin
        cmd_ready = (state == ST_IDLE);
        cmd_fire  = cmd_valid && cmd_ready;
        // valid depends only on registered state, so it cannot drop before its handshake
        ax_valid  = (state == ST_ISSUE) && room;
        ax_fire   = ax_valid && ax_ready;
        ax_addr   = nb.addr;
        ax_len    = nb.axlen;
        ax_size   = AXSIZE;
        ax_burst  = BURST_INCR;
        ax_write  = wr_q;
        resp_err  = resp_valid && resp_code[1];
        done      = done_q;
        err       = err_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            err_seen <= 1'b0;
            wr_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (cmd_fire) begin
                        if (bad) begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                        end else if (empty) begin
                            done_q <= 1'b1;
                        end else begin
                            state    <= ST_ISSUE;
                            wr_q     <= cmd_write;
                            err_seen <= 1'b0;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (resp_err) err_seen <= 1'b1;
                    if (ax_fire && nb.last) state <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (resp_err) err_seen <= 1'b1;
                    if (drained) begin
                        done_q <= 1'b1;
                        err_q  <= err_seen;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cpb_checker.sv
module cpb_checker #(
    parameter int MAX_OUT = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic        ax_valid,
    input logic        ax_ready,
    input logic [31:0] ax_addr,
    input logic [7:0]  ax_len,
    input logic [2:0]  ax_size,
    input logic [1:0]  ax_burst,
    input logic        ax_write,
    input logic        resp_valid,
    input logic        done,
    input logic        err
);
    logic [7:0] pend;

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else pend <= pend + 8'(ax_valid && ax_ready) - 8'(resp_valid);
    end

    a_r1_legal_shape: assert property (@(posedge clk) disable iff (rst)
        ax_valid |-> ((ax_len == 8'd0 || ax_len == 8'd3) && ax_size == 3'd4 && ax_burst == 2'b01));

    a_r2_aligned: assert property (@(posedge clk) disable iff (rst)
        ax_valid |-> (ax_addr[3:0] == 4'd0 && (ax_len != 8'd3 || ax_addr[5:0] == 6'd0)));

    a_r7_credit_limit: assert property (@(posedge clk) disable iff (rst)
        pend <= 8'(MAX_OUT));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_done_drained: assert property (@(posedge clk) disable iff (rst)
        done |-> pend == 8'd0);

    a_r9_err_with_done: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (ax_valid && !ax_ready) |=> (ax_valid && $stable(ax_addr) && $stable(ax_len) && $stable(ax_write)));

    a_r11_busy: assert property (@(posedge clk) disable iff (rst)
        ax_valid |-> !cmd_ready);

    a_r11_accept_idle: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |-> !ax_valid);
endmodule

bind coh_burst_splitter cpb_checker #(.MAX_OUT(MAX_OUTSTANDING)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .ax_valid   (ax_valid),
    .ax_ready   (ax_ready),
    .ax_addr    (ax_addr),
    .ax_len     (ax_len),
    .ax_size    (ax_size),
    .ax_burst   (ax_burst),
    .ax_write   (ax_write),
    .resp_valid (resp_valid),
    .done       (done),
    .err        (err)
);

// File: tb/tb_coh_burst_splitter.sv
module tb_coh_burst_splitter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_addr = '0;
    logic [15:0] cmd_bytes = '0;
    logic        cmd_write = 1'b0;
    logic        ax_valid;
    logic        ax_ready = 1'b0;
    logic [31:0] ax_addr;
    logic [7:0]  ax_len;
    logic [2:0]  ax_size;
    logic [1:0]  ax_burst;
    logic        ax_write;
    logic        resp_valid = 1'b0;
    logic [1:0]  resp_code = 2'b00;
    logic        done;
    logic        err;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // port model state
    int          resp_gap  = 1;
    bit          stall_on  = 0;
    logic [31:0] err_addr  = 32'hFFFF_FFFF;
    logic [31:0] pend_q [0:15];
    int          head = 0, tail = 0, maxo = 0;
    logic [31:0] log_addr [0:255];
    logic [7:0]  log_len  [0:255];
    logic        log_wr   [0:255];
    logic [2:0]  log_size [0:255];
    logic [1:0]  log_burst[0:255];
    int          nlog = 0;
    bit          wait_prev = 0;
    logic [31:0] prev_addr = '0;
    logic [7:0]  prev_len = '0;
    bit          hold_bad = 0;

    coh_burst_splitter dut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_bytes(cmd_bytes), .cmd_write(cmd_write),
        .ax_valid(ax_valid), .ax_ready(ax_ready), .ax_addr(ax_addr), .ax_len(ax_len),
        .ax_size(ax_size), .ax_burst(ax_burst), .ax_write(ax_write),
        .resp_valid(resp_valid), .resp_code(resp_code),
        .done(done), .err(err)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // port model: drives ready and responses half a cycle away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            ax_ready   = 1'b0;
            resp_valid = 1'b0;
        end else begin
            if (head != tail && (cyc % resp_gap) == 0) begin
                resp_valid = 1'b1;
                resp_code  = (pend_q[head % 16] == err_addr) ? 2'b10 : 2'b00;
                head = head + 1;
            end else begin
                resp_valid = 1'b0;
                resp_code  = 2'b00;
            end
            if (wait_prev && !(ax_valid && ax_addr == prev_addr && ax_len == prev_len))
                hold_bad = 1;
            ax_ready = stall_on ? ((cyc % 3) != 0) : 1'b1;
            if (ax_valid && ax_ready) begin
                if (nlog < 256) begin
                    log_addr[nlog]  = ax_addr;
                    log_len[nlog]   = ax_len;
                    log_wr[nlog]    = ax_write;
                    log_size[nlog]  = ax_size;
                    log_burst[nlog] = ax_burst;
                end
                nlog = nlog + 1;
                pend_q[tail % 16] = ax_addr;
                tail = tail + 1;
            end
            wait_prev = ax_valid && !ax_ready;
            prev_addr = ax_addr;
            prev_len  = ax_len;
            if (tail - head > maxo) maxo = tail - head;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // runs one command and checks the burst stream against the split rule
    task automatic run_cmd(input logic [31:0] a, input logic [15:0] n, input logic wr,
                           input bit exp_err, input bit poke, input int exp_maxo);
        bit          seen = 0, err_got = 0, busy_ok = 1;
        logic [31:0] ea;
        int          er, i, bad_idx;
        bit          rejected;
        nlog = 0; maxo = 0; hold_bad = 0;
        head = 0; tail = 0;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_addr = a; cmd_bytes = n; cmd_write = wr; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (poke) begin
            cmd_valid = 1'b1; cmd_addr = 32'h0000_8000; cmd_bytes = 16'd64; cmd_write = ~wr;
        end
        for (int k = 0; k < 20000; k++) begin
            if (done) begin
                seen = 1; err_got = err; cmd_valid = 1'b0;
                break;
            end
            if (cmd_ready) busy_ok = 0;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        @(negedge clk);
        check(!done, "R8", "done pulse width one cycle", done, 0);
        check(seen, "R8", "done seen", seen, 1);
        check(err_got == exp_err, "R9/R5", "err with done", err_got, exp_err);
        if (poke) check(busy_ok, "R11", "cmd_ready low while busy", busy_ok, 1);
        rejected = (a[3:0] != 0) || (n[3:0] != 0);
        // expected split, built from R3
        ea = a; er = int'(n); i = 0; bad_idx = -1;
        if (rejected) er = 0;
        while (er > 0) begin
            bit line = (ea[5:0] == 6'd0) && er >= 64;
            if (i >= nlog || i >= 256) begin
                if (bad_idx < 0) bad_idx = i;
            end else if (log_addr[i] != ea || log_len[i] != (line ? 8'd3 : 8'd0)) begin
                if (bad_idx < 0) bad_idx = i;
            end
            ea = ea + (line ? 32'd64 : 32'd16);
            er = er - (line ? 64 : 16);
            i = i + 1;
        end
        check(nlog == i, "R4/R5/R6", "burst count", nlog, i);
        check(bad_idx < 0, "R3/R4", "first burst differing from split rule at index", bad_idx, -1);
        for (int j = 0; j < nlog && j < 256; j++) begin
            if (log_wr[j] != wr || log_size[j] != 3'd4 || log_burst[j] != 2'b01) begin
                check(0, "R12/R1", "burst direction/size/type at index", j, -1);
                break;
            end
        end
        check(maxo <= 4, "R7", "max outstanding", maxo, 4);
        if (exp_maxo > 0) check(maxo == exp_maxo, "R7", "limit reached", maxo, exp_maxo);
        check(!hold_bad, "R10", "address held until ready", hold_bad, 0);
    endtask

    task automatic t_reset;
        check(cmd_ready == 1'b1, "R11", "reset cmd_ready", cmd_ready, 1);
        check(ax_valid == 1'b0, "R1", "reset ax_valid", ax_valid, 0);
        check(done == 1'b0 && err == 1'b0, "R8", "reset done/err", {done, err}, 0);
    endtask

    task automatic t_full_lines;   // R3 R12: four lines, write
        resp_gap = 1; stall_on = 0;
        run_cmd(32'h0000_1000, 16'd256, 1'b1, 0, 0, 0);
    endtask

    task automatic t_offset_start; // R2 R3: chunks up to a boundary, line, then tail chunks, with stalls
        resp_gap = 2; stall_on = 1;
        run_cmd(32'h0000_1010, 16'd144, 1'b0, 0, 0, 0);
    endtask

    task automatic t_short_tail;   // R3 R4: line then one chunk, read
        resp_gap = 1; stall_on = 0;
        run_cmd(32'h0000_2000, 16'd80, 1'b0, 0, 0, 0);
    endtask

    task automatic t_rejects;      // R5: bad address, bad length
        resp_gap = 1; stall_on = 0;
        run_cmd(32'h0000_3004, 16'd64, 1'b1, 1, 0, 0);
        run_cmd(32'h0000_3000, 16'd20, 1'b1, 1, 0, 0);
    endtask

    task automatic t_zero;         // R6
        run_cmd(32'h0000_4000, 16'd0, 1'b0, 0, 0, 0);
    endtask

    task automatic t_slverr;       // R9: one error mid-stream, then a clean run
        resp_gap = 1; stall_on = 0;
        err_addr = 32'h0000_5040;
        run_cmd(32'h0000_5000, 16'd256, 1'b1, 1, 0, 0);
        err_addr = 32'hFFFF_FFFF;
        run_cmd(32'h0000_5000, 16'd256, 1'b1, 0, 0, 0);
    endtask

    task automatic t_credit;       // R7 R8: slow responses fill the credit window
        resp_gap = 7; stall_on = 0;
        run_cmd(32'h0001_0000, 16'd4096, 1'b0, 0, 0, 4);
    endtask

    task automatic t_busy_cmd;     // R11: command held while busy is ignored
        resp_gap = 3; stall_on = 1;
        run_cmd(32'h0000_6030, 16'd208, 1'b1, 0, 1, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_full_lines();
        t_offset_start();
        t_short_tail();
        t_rejects();
        t_zero();
        t_slverr();
        t_credit();
        t_busy_cmd();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule